// File: doc/BRIEF.md
# Programmable Interval Timer Register Front End

This block is the byte-wide bus side of a three-channel interval timer. A host reaches it through four ports: three counter data ports and one control port. The port index sits in the address above a configurable number of ignored low bits, so the block can sit on a bus with a wider register stride. Through the control port the host sets up a channel's counting mode, freezes a channel's count for a stable read, or takes a snapshot of several channels at once. A snapshot can hold the count, a status byte, or both.

Each channel holds a 16-bit down-counter that steps once per clock while its `count_en` bit is high. Counts move over the 8-bit bus as two transfers, the low byte first. A channel only starts counting once both bytes of a legal count have arrived. Waveform generation is not part of this block. The only output state it keeps is the single bit reported in the status byte. For mode 0 that bit is low from setup or load until the count reaches zero, and for every other mode it stays high.

Top module: `tmr_bus_frontend`

## Requirements
- R1: The port index is `bus_addr[REG_SHIFT+1:REG_SHIFT]`, and the address bits below `REG_SHIFT` are ignored. Indices 0, 1 and 2 are the counter data ports and index 3 is the control port. A read of the control port returns 0x00.
- R2: A control word with bits 5:4 = 11 and bits 7:6 not equal to 11 sets up the channel named in bits 7:6 (00, 01 or 10). Bits 3:1 give the mode and bit 0 selects BCD counting.
- R3: A control word with bits 7:6 ≠ 11 is rejected when bits 5:4 are 01 or 10, or when bits 3:1 are 6 or 7. `ctl_reject` is then high for exactly the cycle after the write, and the channel's setup is unchanged.
- R4: A count is written as the low byte and then the high byte on the channel's data port. Null-count (status bit 6) is set by a mode setup and by the low-byte write. It clears when the complete count is transferred on the high-byte write. Data writes to a channel with no accepted setup since reset are ignored.
- R5: A loaded channel decrements by one on each clock with its `count_en` bit high. In binary mode a written count of 0 acts as 65536, so one step leaves 0xFFFF.
- R6: With BCD selected, the counter decrements as four decimal digits. One step takes 0x0100 to 0x0099, and a loaded count of 0 steps to 0x9999.
- R7: A control word with bits 5:4 = 00 latches the count of the channel in bits 7:6. The next two reads of that port return the latched low byte and then the high byte, whatever the counter does meanwhile. After that, reads return the live count, low byte then high byte.
- R8: A count latch command or a status latch command leaves an existing, not fully read latch of the same kind unchanged.
- R9: Control word 11 c s m2 m1 m0 x is a read-back command. It applies to each channel n whose mask bit (bit n+1) is set. It latches the count when c = 0 and the status when s = 0. A pending status byte is returned by the next read, before any latched count bytes.
- R10: The status byte is {out, null-count, access field 5:4 of the last accepted setup, mode, BCD}. After reset it reads 0x40.
- R11: In modes 2 and 3, a complete count of 1 sets `load_fault` for that channel, is not transferred, and leaves null-count set. The next legal load or mode setup clears the flag.
- R12: The status out bit goes low on a mode-0 setup and on a mode-0 count load. It goes high on the step that brings the count to zero. In every other mode it is high after setup.
- R13: `bus_rdata` is registered. It shows the read byte in the cycle after `bus_rd`, holds until the next read, and resets to 0x00. `ctl_reject` and `load_fault` reset low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | REG_SHIFT+2 | Register address, port index above REG_SHIFT ignored bits |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| count_en | input | 3 | Per-channel count step enable |
| ctl_reject | output | 1 | One-cycle pulse after a rejected control word |
| load_fault | output | 3 | Per-channel illegal-count flag |

## Verification
The hardest state to reach from the ports is a latched count held while the live counter keeps moving, followed by a second latch command arriving before the first latch is fully read. The stimulus steps the counter by a known number of `count_en` cycles between each latch and each read. This makes the frozen value and the live value differ in both bytes. A combined read-back that latches status and count together exercises the read order. Zero and BCD-borrow loads exercise the wrap values.

// File: rtl/tmr_pkg.sv
// Package: shared constants, the channel setup record and the counter step
// function for the interval timer front end. Assumes three channels.
package tmr_pkg;
    localparam int CH_COUNT = 3;
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = 2 * BYTE_W;
    localparam int DIGITS   = CNT_W / 4;
    localparam logic [2:0] MODE_MAX = 3'd5;
    localparam logic [1:0] ACC_LOHI = 2'b11;
    localparam logic [1:0] ACC_LATCH = 2'b00;
    localparam logic [1:0] SEL_RDBACK = 2'b11;

    typedef struct packed {
        logic [1:0] acc;
        logic [2:0] mode;
        logic       bcd;
    } chcfg_t;

    // One down-step of the counter, binary or four-digit decimal.
    function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v,
                                                   input logic bcd);
        logic [CNT_W-1:0] r;
        logic borrow;
        if (!bcd) begin
            r = v - 1'b1;
        end else begin
            r = v;
            borrow = 1'b1;
            for (int d = 0; d < DIGITS; d++) begin
                if (borrow) begin
                    if (v[4*d +: 4] == 4'd0) begin
                        r[4*d +: 4] = 4'd9;
                    end else begin
                        r[4*d +: 4] = v[4*d +: 4] - 4'd1;
                        borrow = 1'b0;
                    end
                end
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/tmr_ctl_decode.sv
// Control word decoder. Turns one control-port write into per-channel
// setup strobes, latch strobes and a reject flag. Assumes ctl_we is a
// single-cycle strobe; outputs are combinational.
module tmr_ctl_decode
    import tmr_pkg::*;
(
    input  logic                 ctl_we,
    input  logic [BYTE_W-1:0]    ctl_word,
    output logic [CH_COUNT-1:0]  setup_we,
    output chcfg_t               setup_cfg,
    output logic [CH_COUNT-1:0]  grab_cnt,
    output logic [CH_COUNT-1:0]  grab_sts,
    output logic                 bad_word
);
    logic [1:0] sel;
    logic [1:0] acc;
    logic [2:0] mode;

    assign sel  = ctl_word[7:6];
    assign acc  = ctl_word[5:4];
    assign mode = ctl_word[3:1];
    assign setup_cfg = '{acc: ACC_LOHI, mode: mode, bcd: ctl_word[0]};

    // Classify the control word and fan it out to channels.
    always_comb begin
        setup_we = '0;
        grab_cnt = '0;
        grab_sts = '0;
        bad_word = 1'b0;
        if (ctl_we) begin
            if (sel == SEL_RDBACK) begin
                for (int ch = 0; ch < CH_COUNT; ch++) begin
                    if (ctl_word[1+ch]) begin
                        grab_cnt[ch] = !ctl_word[5];
                        grab_sts[ch] = !ctl_word[4];
                    end
                end
            end else if (acc == ACC_LATCH) begin
                for (int ch = 0; ch < CH_COUNT; ch++)
                    if (sel == 2'(ch)) grab_cnt[ch] = 1'b1;
            end else if (acc == ACC_LOHI && mode <= MODE_MAX) begin
                for (int ch = 0; ch < CH_COUNT; ch++)
                    if (sel == 2'(ch)) setup_we[ch] = 1'b1;
            end else begin
                bad_word = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tmr_channel.sv
// One timer channel: setup record, two-byte count write sequencing, the
// down-counter, count and status latches and the read byte sequencing.
// Assumes at most one of setup_we, grab_*, data_we, data_re per cycle.
module tmr_channel
    import tmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               setup_we,
    input  chcfg_t             setup_cfg,
    input  logic               grab_cnt,
    input  logic               grab_sts,
    input  logic               data_we,
    input  logic               data_re,
    input  logic [BYTE_W-1:0]  wdata,
    input  logic               cnt_en,
    output logic [BYTE_W-1:0]  rd_byte,
    output logic               load_fault
);
    chcfg_t             cfg_q;
    logic [BYTE_W-1:0]  stage_q;
    logic               wr_hi_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               armed_q;
    logic               null_q;
    logic               out_q;
    logic               fault_q;
    logic               rd_hi_q;
    logic               cl_valid_q;
    logic [CNT_W-1:0]   cl_val_q;
    logic               sl_valid_q;
    logic [BYTE_W-1:0]  sl_val_q;

    logic               configured;
    logic               commit;
    logic               bad_load;
    logic               tick;
    logic [CNT_W-1:0]   full_word;
    logic [CNT_W-1:0]   next_cnt;
    logic [BYTE_W-1:0]  status_now;
    logic [CNT_W-1:0]   rd_src;

    assign configured = (cfg_q.acc == ACC_LOHI);
    assign full_word  = {wdata, stage_q};
    assign commit     = data_we && configured && wr_hi_q;
    assign bad_load   = (cfg_q.mode == 3'd2 || cfg_q.mode == 3'd3) &&
                        (full_word == CNT_W'(1));
    assign tick       = armed_q && cnt_en && !commit;
    assign next_cnt   = step_down(cnt_q, cfg_q.bcd);
    assign status_now = {out_q, null_q, cfg_q.acc, cfg_q.mode, cfg_q.bcd};
    assign load_fault = fault_q;

    // Hold the accepted setup record.
    always_ff @(posedge clk) begin
        if (!rst_n)        cfg_q <= '0;
        else if (setup_we) cfg_q <= setup_cfg;
    end

    // Sequence count writes as low byte then high byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_hi_q <= 1'b0;
            stage_q <= '0;
        end else if (setup_we) begin
            wr_hi_q <= 1'b0;
        end else if (data_we && configured) begin
            if (!wr_hi_q) stage_q <= wdata;
            wr_hi_q <= !wr_hi_q;
        end
    end

    // Counting element, null-count, out bit and illegal-load flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            null_q  <= 1'b1;
            out_q   <= 1'b0;
            fault_q <= 1'b0;
        end else if (setup_we) begin
            armed_q <= 1'b0;
            null_q  <= 1'b1;
            out_q   <= (setup_cfg.mode != 3'd0);
            fault_q <= 1'b0;
        end else if (commit) begin
            if (bad_load) begin
                fault_q <= 1'b1;
            end else begin
                cnt_q   <= full_word;
                armed_q <= 1'b1;
                null_q  <= 1'b0;
                fault_q <= 1'b0;
                out_q   <= (cfg_q.mode != 3'd0);
            end
        end else begin
            if (data_we && configured) null_q <= 1'b1;
            if (tick) begin
                cnt_q <= next_cnt;
                if (cfg_q.mode == 3'd0 && next_cnt == '0) out_q <= 1'b1;
            end
        end
    end

    // Latch captures and read byte sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_hi_q    <= 1'b0;
            cl_valid_q <= 1'b0;
            cl_val_q   <= '0;
            sl_valid_q <= 1'b0;
            sl_val_q   <= '0;
        end else begin
            if (setup_we) rd_hi_q <= 1'b0;
            if (grab_cnt && !cl_valid_q) begin
                cl_valid_q <= 1'b1;
                cl_val_q   <= cnt_q;
            end
            if (grab_sts && !sl_valid_q) begin
                sl_valid_q <= 1'b1;
                sl_val_q   <= status_now;
            end
            if (data_re) begin
                if (sl_valid_q) begin
                    sl_valid_q <= 1'b0;
                end else begin
                    rd_hi_q <= !rd_hi_q;
                    if (cl_valid_q && rd_hi_q) cl_valid_q <= 1'b0;
                end
            end
        end
    end

    // Select the byte a read of this port returns.
    always_comb begin
        rd_src = cl_valid_q ? cl_val_q : cnt_q;
        if (sl_valid_q)   rd_byte = sl_val_q;
        else if (rd_hi_q) rd_byte = rd_src[CNT_W-1:BYTE_W];
        else              rd_byte = rd_src[BYTE_W-1:0];
    end

    // Null-count clears only on a data write (count transfer).
    assert_null_clears_on_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(null_q) |-> $past(data_we));

    // The count moves only when stepped or loaded.
    assert_count_moves_with_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_q) |-> $past(cnt_en || data_we));

    // A held count latch keeps its value until released.
    assert_latch_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cl_valid_q |=> (cl_valid_q -> $stable(cl_val_q)));

    // A status read does not advance the count byte order.
    assert_status_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_re && sl_valid_q) |=> $stable(rd_hi_q));

    // An illegal load leaves null-count set.
    assert_fault_keeps_null_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_q) |-> null_q);
endmodule

// File: rtl/tmr_bus_frontend.sv
// Top of the interval timer bus front end. Decodes the port index from
// the address above REG_SHIFT ignored bits, routes control writes to the
// decoder and data accesses to the channels, and registers read data.
// Assumes bus_wr and bus_rd are never high together.
module tmr_bus_frontend
    import tmr_pkg::*;
#(
    parameter  int REG_SHIFT = 0,
    localparam int ADDR_W    = REG_SHIFT + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [BYTE_W-1:0]    bus_wdata,
    output logic [BYTE_W-1:0]    bus_rdata,
    input  logic [CH_COUNT-1:0]  count_en,
    output logic                 ctl_reject,
    output logic [CH_COUNT-1:0]  load_fault
);
    localparam logic [1:0] CTL_PORT = 2'd3;

    logic [1:0]              port;
    logic                    ctl_we;
    logic [CH_COUNT-1:0]     setup_we;
    chcfg_t                  setup_cfg;
    logic [CH_COUNT-1:0]     grab_cnt;
    logic [CH_COUNT-1:0]     grab_sts;
    logic                    bad_word;
    logic [CH_COUNT-1:0]     data_we;
    logic [CH_COUNT-1:0]     data_re;
    logic [BYTE_W-1:0]       ch_byte [CH_COUNT];
    logic [BYTE_W-1:0]       rd_pick;

    assign port   = bus_addr[REG_SHIFT +: 2];
    assign ctl_we = bus_wr && (port == CTL_PORT);

    tmr_ctl_decode u_decode (
        .ctl_we    (ctl_we),
        .ctl_word  (bus_wdata),
        .setup_we  (setup_we),
        .setup_cfg (setup_cfg),
        .grab_cnt  (grab_cnt),
        .grab_sts  (grab_sts),
        .bad_word  (bad_word)
    );

    for (genvar g = 0; g < CH_COUNT; g++) begin : g_ch
        assign data_we[g] = bus_wr && (port == 2'(g));
        assign data_re[g] = bus_rd && (port == 2'(g));

        tmr_channel u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .setup_we   (setup_we[g]),
            .setup_cfg  (setup_cfg),
            .grab_cnt   (grab_cnt[g]),
            .grab_sts   (grab_sts[g]),
            .data_we    (data_we[g]),
            .data_re    (data_re[g]),
            .wdata      (bus_wdata),
            .cnt_en     (count_en[g]),
            .rd_byte    (ch_byte[g]),
            .load_fault (load_fault[g])
        );
    end

    // Pick the addressed channel's byte; the control port reads as zero.
    always_comb begin
        rd_pick = '0;
        for (int ch = 0; ch < CH_COUNT; ch++)
            if (port == 2'(ch)) rd_pick = ch_byte[ch];
    end

    // Register read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_pick;
    end

    // Register the reject pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_reject <= 1'b0;
        else        ctl_reject <= bad_word;
    end

    // A reject pulse always follows a write.
    assert_reject_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_reject |-> $past(bus_wr));

    // Read data changes only after a read strobe.
    assert_rdata_holds_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bus_rdata) |-> $past(bus_rd));
endmodule

// File: tb/test_tmr_bus_frontend.sv
`timescale 1ns/1ps
module test_tmr_bus_frontend;
    localparam int SH = 2;
    localparam int AW = SH + 2;
    localparam logic [1:0] OP_W = 2'd0;
    localparam logic [1:0] OP_R = 2'd1;
    localparam logic [1:0] OP_T = 2'd2;
    localparam int NV = 56;

    typedef struct packed {
        logic [1:0] op;
        logic [1:0] port;
        logic [7:0] data;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    // op, port, data (write byte or tick count), expected read, requirement
    localparam logic [23:0] TBL [NV] = '{
        {OP_W, 2'd3, 8'hE2, 8'h00, 4'd9},   // R9 status snapshot after reset
        {OP_R, 2'd0, 8'h00, 8'h40, 4'd10},  // R10 reset status
        {OP_W, 2'd3, 8'h34, 8'h00, 4'd2},   // R2 ch0 mode 2 binary
        {OP_W, 2'd3, 8'hE2, 8'h00, 4'd9},
        {OP_R, 2'd0, 8'h00, 8'hF4, 4'd10},  // R10 R12 out high, null set
        {OP_W, 2'd0, 8'h05, 8'h00, 4'd4},   // R4 low byte
        {OP_W, 2'd3, 8'hE2, 8'h00, 4'd4},
        {OP_R, 2'd0, 8'h00, 8'hF4, 4'd4},   // R4 null still set
        {OP_W, 2'd0, 8'h01, 8'h00, 4'd4},   // R4 high byte -> 0x0105
        {OP_W, 2'd3, 8'hE2, 8'h00, 4'd4},
        {OP_R, 2'd0, 8'h00, 8'hB4, 4'd4},   // R4 null cleared
        {OP_T, 2'd0, 8'd3,  8'h00, 4'd5},   // R5 -> 0x0102
        {OP_W, 2'd3, 8'h00, 8'h00, 4'd7},   // R7 latch 0x0102
        {OP_T, 2'd0, 8'd2,  8'h00, 4'd7},
        {OP_R, 2'd0, 8'h00, 8'h02, 4'd7},
        {OP_T, 2'd0, 8'd1,  8'h00, 4'd7},
        {OP_R, 2'd0, 8'h00, 8'h01, 4'd7},
        {OP_R, 2'd0, 8'h00, 8'hFF, 4'd7},   // R7 live 0x00FF
        {OP_R, 2'd0, 8'h00, 8'h00, 4'd7},
        {OP_W, 2'd3, 8'h00, 8'h00, 4'd8},   // R8 latch 0x00FF
        {OP_T, 2'd0, 8'd1,  8'h00, 4'd8},
        {OP_W, 2'd3, 8'h00, 8'h00, 4'd8},   // R8 ignored
        {OP_R, 2'd0, 8'h00, 8'hFF, 4'd8},
        {OP_R, 2'd0, 8'h00, 8'h00, 4'd8},
        {OP_W, 2'd3, 8'h71, 8'h00, 4'd2},   // R2 ch1 mode 0 BCD
        {OP_W, 2'd3, 8'hE4, 8'h00, 4'd9},
        {OP_R, 2'd1, 8'h00, 8'h71, 4'd10},
        {OP_W, 2'd1, 8'h00, 8'h00, 4'd6},   // R6 load 0x0100
        {OP_W, 2'd1, 8'h01, 8'h00, 4'd6},
        {OP_T, 2'd1, 8'd1,  8'h00, 4'd6},
        {OP_W, 2'd3, 8'h40, 8'h00, 4'd6},
        {OP_R, 2'd1, 8'h00, 8'h99, 4'd6},   // R6 decimal borrow
        {OP_R, 2'd1, 8'h00, 8'h00, 4'd6},
        {OP_W, 2'd1, 8'h02, 8'h00, 4'd12},  // R12 load 2
        {OP_W, 2'd1, 8'h00, 8'h00, 4'd12},
        {OP_W, 2'd3, 8'hE4, 8'h00, 4'd12},
        {OP_R, 2'd1, 8'h00, 8'h31, 4'd12},  // R12 out low
        {OP_T, 2'd1, 8'd2,  8'h00, 4'd12},
        {OP_W, 2'd3, 8'hE4, 8'h00, 4'd12},
        {OP_R, 2'd1, 8'h00, 8'hB1, 4'd12},  // R12 out high at zero
        {OP_W, 2'd3, 8'hC4, 8'h00, 4'd9},   // R9 count and status
        {OP_R, 2'd1, 8'h00, 8'hB1, 4'd9},
        {OP_R, 2'd1, 8'h00, 8'h00, 4'd9},
        {OP_R, 2'd1, 8'h00, 8'h00, 4'd9},
        {OP_W, 2'd3, 8'hB0, 8'h00, 4'd5},   // R5 ch2 mode 0 binary
        {OP_W, 2'd2, 8'h00, 8'h00, 4'd5},
        {OP_W, 2'd2, 8'h00, 8'h00, 4'd5},
        {OP_T, 2'd2, 8'd1,  8'h00, 4'd5},
        {OP_W, 2'd3, 8'h80, 8'h00, 4'd5},
        {OP_R, 2'd2, 8'h00, 8'hFF, 4'd5},   // R5 zero acts as 65536
        {OP_R, 2'd2, 8'h00, 8'hFF, 4'd5},
        {OP_W, 2'd3, 8'h9C, 8'h00, 4'd3},   // R3 access 01
        {OP_W, 2'd3, 8'hBC, 8'h00, 4'd3},   // R3 mode 6
        {OP_W, 2'd3, 8'hE8, 8'h00, 4'd3},
        {OP_R, 2'd2, 8'h00, 8'h30, 4'd3},   // R3 setup unchanged
        {OP_R, 2'd3, 8'h00, 8'h00, 4'd1}    // R1 control port reads 0
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [2:0]    count_en = '0;
    logic          ctl_reject;
    logic [2:0]    load_fault;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tmr_bus_frontend #(.REG_SHIFT(SH)) i_tmr_bus_frontend (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count_en(count_en), .ctl_reject(ctl_reject), .load_fault(load_fault)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr_raw(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_raw(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic tick(input int ch, input int n);
        @(negedge clk);
        count_en[ch] = 1'b1;
        for (int k = 0; k < n; k++) @(negedge clk);
        count_en[ch] = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [AW-1:0] pa(input logic [1:0] p);
        return AW'(p) << SH;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        do_reset();
        @(negedge clk);
        // R13 reset values
        check("R13 reset rdata", bus_rdata, 8'h00);
        check("R13 reset ctl_reject", {7'd0, ctl_reject}, 8'h00);
        check("R13 reset load_fault", {5'd0, load_fault}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = vec_t'(TBL[i]);
            case (v.op)
                OP_W: wr_raw(pa(v.port), v.data);
                OP_R: begin
                    rd_raw(pa(v.port), got);
                    check($sformatf("R%0d table row %0d", v.req, i), got, v.exp);
                end
                default: tick(int'(v.port), int'(v.data));
            endcase
        end

        // R3 reject pulse timing
        wr_raw(pa(2'd3), 8'h5A);
        check("R3 reject pulse high", {7'd0, ctl_reject}, 8'h01);
        @(negedge clk);
        check("R3 reject pulse one cycle", {7'd0, ctl_reject}, 8'h00);

        // R11 illegal count 1 in mode 2 on ch0
        wr_raw(pa(2'd0), 8'h01);
        wr_raw(pa(2'd0), 8'h00);
        check("R11 fault set", {5'd0, load_fault}, 8'h01);
        wr_raw(pa(2'd3), 8'hE2);
        rd_raw(pa(2'd0), got);
        check("R11 null stays set", got, 8'hF4);
        wr_raw(pa(2'd0), 8'h03);
        wr_raw(pa(2'd0), 8'h00);
        check("R11 fault cleared by legal load", {5'd0, load_fault}, 8'h00);
        wr_raw(pa(2'd3), 8'h00);
        rd_raw(pa(2'd0), got);
        check("R11 legal count loaded", got, 8'h03);
        rd_raw(pa(2'd0), got);
        // R13 read data holds
        repeat (3) @(negedge clk);
        check("R13 rdata holds", bus_rdata, 8'h00);

        // R4 writes before setup ignored; R1 low address bits ignored
        do_reset();
        wr_raw(4'b0001, 8'h12);
        wr_raw(4'b0010, 8'h34);
        wr_raw(4'b1111, 8'h00);
        rd_raw(4'b0011, got);
        check("R4 unconfigured low", got, 8'h00);
        rd_raw(4'b0001, got);
        check("R4 unconfigured high", got, 8'h00);
        wr_raw(4'b1110, 8'hE2);
        rd_raw(4'b0010, got);
        check("R1 stride decode status", got, 8'h40);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule